// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is one general-purpose I/O port of configurable width (eight bits by default). Software reaches it through a small register bus with a select, a write strobe, a three-bit register address and a write data word. Read data is returned combinationally in the same cycle. Every bit position carries the same set of control and data bits. These bits are implemented for all positions even when a product bonds out only some of the pins.

Each pin input passes through a two-flop synchronizer. The synchronized value is what software reads back, and it is also what the edge detector watches. A per-bit polarity bit picks the rising or the falling transition. When the picked transition appears, the matching pending flag is set. A single request line is raised while any pending flag has its enable bit set. On the output side, a direction bit drives each pin's output enable. A per-bit function-select bit passes either the port's own output latch or an alternate signal from another module to the pin.

Register map, addressed by `bus_addr`: 0 pin level (read only), 1 output latch, 2 direction, 3 edge polarity, 4 pending flags, 5 interrupt enable, 6 function select, 7 unmapped.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, registers 1 to 6 read 0, `pin_oe` is 0 and `irq` is 0.
- R2: Address 0 returns the pin levels through a two-flop synchronizer. A pin change made after clock edge P0 is first visible in a read made after edge P2. A write to address 0 changes no register.
- R3: `pin_oe` bit i equals direction bit i (1 = drive) from the cycle after the write. Address 1 and address 2 read back what was written.
- R4: Where function-select bit i is 1, `pin_out[i]` follows `alt_out[i]`. Where it is 0, `pin_out[i]` follows the output latch bit.
- R5: With polarity bit 0, a 0-to-1 transition of a synchronized input sets its flag. For a pin change after edge P0, the flag reads 1 after edge P3 and still reads 0 before it.
- R6: With polarity bit 1, a 1-to-0 transition sets the flag, and a 0-to-1 transition does not.
- R7: A write to address 4 loads the flag register. A 0 clears a flag and a 1 sets it.
- R8: If a selected edge is detected in the same cycle as a write of 0 to that flag, the flag ends up set.
- R9: Writing the polarity register does not set any flag by itself, even while pins are high.
- R10: `irq` is 1 exactly when some bit has both its flag and its enable set.
- R11: Address 7 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read while selected |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not selected |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| alt_out | input | 8 | Alternate-function output values |
| pin_out | output | 8 | Value driven toward each pad |
| pin_oe | output | 8 | Output enable per pad |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach from the ports is a flag-clear write that arrives in the same cycle as the edge detector reporting a transition. Both the synchronizer delay and the detector's history register sit between the pin and the flag. The stimulus changes a pin right after a clock edge and waits exactly two edges. It then issues the clear write, so the write commits on the third edge, which is the edge where the hardware set also lands. It reads back a set flag. A control write of 0 with no edge in flight confirms that the same write does clear.

// File: rtl/gpio_port_pkg.sv
// Package: shared register addresses for the edge-interrupt GPIO port.
// Assumes a three-bit register address; the unmapped slot reads as zero.
package gpio_port_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RS_LEVEL = 3'd0,
        RS_LATCH = 3'd1,
        RS_DIR   = 3'd2,
        RS_POL   = 3'd3,
        RS_FLAG  = 3'd4,
        RS_IEN   = 3'd5,
        RS_FSEL  = 3'd6,
        RS_NONE  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: per-bit multi-flop synchronizer for asynchronous pad inputs.
// Assumes STAGES >= 2; the output is the last flop of each bit's chain.
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);

    localparam int TOP = STAGES - 1;

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the pad level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], pin_async[b]};
                end
            end

            assign pin_sync[b] = chain[TOP];
        end
    endgenerate

endmodule

// File: rtl/gpio_edge_flags.sv
// Module: edge detector and pending-flag register.
// A history flop holds last cycle's synchronized level. The polarity bit
// picks the transition that counts. A detected edge outranks a software
// load of the same bit. Polarity changes cannot create an edge.
module gpio_edge_flags #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_sync,
    input  logic [WIDTH-1:0] pol_q,
    input  logic             flag_wr,
    input  logic [WIDTH-1:0] flag_wdata,
    output logic [WIDTH-1:0] flag_q,
    output logic [WIDTH-1:0] edge_hit
);

    logic [WIDTH-1:0] lvl_prev;

    // Remember the previous synchronized level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= '0;
        end else begin
            lvl_prev <= lvl_sync;
        end
    end

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            // Select the rising or falling transition per the polarity bit.
            always_comb begin
                if (pol_q[b]) begin
                    edge_hit[b] = lvl_prev[b] & ~lvl_sync[b];
                end else begin
                    edge_hit[b] = lvl_sync[b] & ~lvl_prev[b];
                end
            end

            // Update the flag: hardware set first, then software load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[b] <= 1'b0;
                end else if (edge_hit[b]) begin
                    flag_q[b] <= 1'b1;
                end else if (flag_wr) begin
                    flag_q[b] <= flag_wdata[b];
                end
            end
        end
    endgenerate

    // R5/R6: a detected edge leaves its flag set on the next cycle.
    a_r5_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

    // R7: a flag only rises from an edge or a software load.
    a_r7_flag_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(edge_hit)) != '0) |-> $past(flag_wr));

endmodule

// File: rtl/gpio_regfile.sv
// Module: register bank and read multiplexer of the GPIO port.
// Holds latch, direction, polarity, enable and function-select registers.
// It produces a load strobe for the flag register, which lives in the
// edge block. Reads are combinational and return 0 when not selected.
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    input  logic [WIDTH-1:0]      lvl_sync,
    input  logic [WIDTH-1:0]      flag_q,
    output logic [WIDTH-1:0]      latch_q,
    output logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      pol_q,
    output logic [WIDTH-1:0]      ien_q,
    output logic [WIDTH-1:0]      fsel_q,
    output logic                  flag_wr,
    output logic [WIDTH-1:0]      flag_wdata,
    output logic [WIDTH-1:0]      bus_rdata
);

    reg_sel_e sel;
    logic     wr_en;

    assign sel        = reg_sel_e'(bus_addr);
    assign wr_en      = bus_sel & bus_wr;
    assign flag_wr    = wr_en && (sel == RS_FLAG);
    assign flag_wdata = bus_wdata;

    // Output latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else if (wr_en && sel == RS_LATCH) latch_q <= bus_wdata;
    end

    // Direction register (1 = drive the pin).
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else if (wr_en && sel == RS_DIR) dir_q <= bus_wdata;
    end

    // Edge polarity register (0 = rising, 1 = falling).
    always_ff @(posedge clk) begin
        if (!rst_n) pol_q <= '0;
        else if (wr_en && sel == RS_POL) pol_q <= bus_wdata;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) ien_q <= '0;
        else if (wr_en && sel == RS_IEN) ien_q <= bus_wdata;
    end

    // Function-select register (1 = alternate module signal).
    always_ff @(posedge clk) begin
        if (!rst_n) fsel_q <= '0;
        else if (wr_en && sel == RS_FSEL) fsel_q <= bus_wdata;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                RS_LEVEL: bus_rdata = lvl_sync;
                RS_LATCH: bus_rdata = latch_q;
                RS_DIR:   bus_rdata = dir_q;
                RS_POL:   bus_rdata = pol_q;
                RS_FLAG:  bus_rdata = flag_q;
                RS_IEN:   bus_rdata = ien_q;
                RS_FSEL:  bus_rdata = fsel_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R2/R11: writes to the level or unmapped slot leave every register unchanged.
    a_r11_dead_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == RS_LEVEL || sel == RS_NONE)) |=>
        $stable({latch_q, dir_q, pol_q, ien_q, fsel_q}));

    // R11: the unmapped slot reads zero.
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && sel == RS_NONE) |-> (bus_rdata == '0));

endmodule

// File: rtl/gpio_edge_port.sv
// Module: top of the edge-interrupt GPIO port.
// Connects the synchronizer, register bank and edge/flag block. Drives the
// pin mux and the shared interrupt line. Assumes pin_in is asynchronous
// and that alt_out is already in this clock domain.
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      pin_in,
    input  logic [WIDTH-1:0]      alt_out,
    output logic [WIDTH-1:0]      pin_out,
    output logic [WIDTH-1:0]      pin_oe,
    output logic                  irq
);

    logic [WIDTH-1:0] lvl_sync;
    logic [WIDTH-1:0] latch_q, dir_q, pol_q, ien_q, fsel_q;
    logic [WIDTH-1:0] flag_q, flag_wdata, edge_hit;
    logic             flag_wr;

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (lvl_sync)
    );

    gpio_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .lvl_sync   (lvl_sync),
        .flag_q     (flag_q),
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .pol_q      (pol_q),
        .ien_q      (ien_q),
        .fsel_q     (fsel_q),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .bus_rdata  (bus_rdata)
    );

    gpio_edge_flags #(.WIDTH(WIDTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_sync   (lvl_sync),
        .pol_q      (pol_q),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .flag_q     (flag_q),
        .edge_hit   (edge_hit)
    );

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_pin
            // Route the latch or the alternate signal to each pin.
            assign pin_out[b] = fsel_q[b] ? alt_out[b] : latch_q[b];
        end
    endgenerate

    assign pin_oe = dir_q;

    // Raise the shared request from any enabled pending flag.
    assign irq = |(flag_q & ien_q);

    // R1: coming out of reset the pins are undriven and no request is up.
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (pin_oe == '0 && !irq));

    // R3: a direction write appears on pin_oe one cycle later.
    a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RS_DIR) |=> (pin_oe == $past(bus_wdata)));

    // R9: a polarity write with no edge in flight leaves the flags alone.
    a_r9_pol_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RS_POL && edge_hit == '0) |=> $stable(flag_q));

    // R10: a request needs both a pending flag and an enable.
    a_r10_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q != '0 && flag_q != '0));

endmodule

// File: tb/gpio_edge_port_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] alt_out = 8'h3C;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Scoreboard queues: source (0 rdata, 1 pin_out, 2 pin_oe, 3 irq), expected, tag.
    int         src_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    gpio_edge_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .alt_out(alt_out), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    // Monitor: pop one expected item per cycle and compare away from the edge.
    always @(negedge clk) begin
        if (src_q.size() > 0) begin
            int         s;
            logic [7:0] e;
            logic [7:0] a;
            string      t;
            s = src_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            case (s)
                0: a = bus_rdata;
                1: a = pin_out;
                2: a = pin_oe;
                default: a = {7'd0, irq};
            endcase
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog (all reqs): actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Tasks start and end one time unit after a rising edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        src_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
        tick(1);
        bus_sel = 1'b0;
    endtask

    task automatic see(input int s, input logic [7:0] e, input string t);
        src_q.push_back(s); exp_q.push_back(e); tag_q.push_back(t);
        tick(1);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state.
        for (int a = 1; a <= 6; a++) rd(3'(a), 8'h00, "R1 reg reset");
        see(2, 8'h00, "R1 pin_oe reset");
        see(3, 8'h00, "R1 irq reset");

        // R3: latch and direction.
        wr(3'd1, 8'hA5);
        wr(3'd2, 8'h0F);
        see(1, 8'hA5, "R3 pin_out latch");
        see(2, 8'h0F, "R3 pin_oe dir");
        rd(3'd1, 8'hA5, "R3 latch readback");
        rd(3'd2, 8'h0F, "R3 dir readback");

        // R4: function select mixes alternate and latch.
        wr(3'd6, 8'hF0);
        see(1, 8'h35, "R4 mixed pin_out");
        rd(3'd6, 8'hF0, "R4 fsel readback");
        wr(3'd6, 8'h00);
        see(1, 8'hA5, "R4 latch restored");

        // R2 + R5: synchronizer latency and rising-edge flag timing.
        pin_in = 8'h81;
        rd(3'd0, 8'h00, "R2 level before P1");
        rd(3'd0, 8'h00, "R2 level before P2");
        rd(3'd4, 8'h00, "R5 flag not before P3");
        rd(3'd4, 8'h81, "R5 rising flag set");
        wr(3'd0, 8'hFF);
        rd(3'd0, 8'h81, "R2 level unchanged by write");
        rd(3'd1, 8'hA5, "R2 latch untouched");

        // R7: software clear and set.
        wr(3'd4, 8'h00);
        rd(3'd4, 8'h00, "R7 flag cleared");
        wr(3'd4, 8'h04);
        rd(3'd4, 8'h04, "R7 flag set by write");
        wr(3'd4, 8'h00);

        // R9: polarity write with pins high sets nothing.
        wr(3'd3, 8'hFF);
        tick(3);
        rd(3'd4, 8'h00, "R9 no flag from polarity write");

        // R6: falling edges count, rising ones do not.
        pin_in = 8'h00;
        tick(4);
        rd(3'd4, 8'h81, "R6 falling flag set");
        pin_in = 8'h02;
        tick(4);
        rd(3'd4, 8'h81, "R6 rising ignored");

        // R10: request gating.
        see(3, 8'h00, "R10 irq off without enable");
        wr(3'd5, 8'h01);
        see(3, 8'h01, "R10 irq on bit0");
        wr(3'd4, 8'h80);
        see(3, 8'h00, "R10 irq off, flag7 not enabled");
        wr(3'd5, 8'h80);
        see(3, 8'h01, "R10 irq on bit7");
        wr(3'd4, 8'h00);
        see(3, 8'h00, "R10 irq off after clear");

        // R8: edge and clear in the same cycle; edge wins.
        wr(3'd3, 8'h00);
        pin_in = 8'h12;
        tick(2);
        wr(3'd4, 8'h00);
        rd(3'd4, 8'h10, "R8 edge beats clear");
        wr(3'd4, 8'h00);
        rd(3'd4, 8'h00, "R8 clear without edge");

        // R11: unmapped slot.
        rd(3'd7, 8'h00, "R11 unmapped reads zero");
        wr(3'd7, 8'hFF);
        rd(3'd1, 8'hA5, "R11 latch untouched");
        rd(3'd2, 8'h0F, "R11 dir untouched");
        rd(3'd5, 8'h80, "R11 enable untouched");

        tick(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule